// File: doc/BRIEF.md
# Multicast Hash Filter

This block screens destination MAC addresses against a 256-entry single-bit hash table. A client hands it a 48-bit address with an operation code. The block runs the address through the Ethernet CRC-32 one byte per clock. It takes the top eight bits of the CRC register as a table index and then either reports whether that table entry is set (lookup) or writes that entry (set or clear). Only addresses with the group bit set can be accepted, so unicast traffic is never passed by this filter.

The table is stored as eight 32-bit registers. A host port reads them and writes them directly, so software can load a whole hash image at once. It can also add or remove single addresses through the command port and leave the index arithmetic to the hardware. Every register resets to zero, so no address is accepted until the table is loaded.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, busy_o, done_o and accept_o are 0 and all eight table registers read as zero.
- R2: A host write (host_we_i=1) stores host_wdata_i into register host_addr_i at the clock edge. host_rdata_o shows register host_addr_i combinationally.
- R3: The index is bits [31:24] of a 32-bit CRC register. The register starts at all ones and shifts MSB-first with polynomial 0x04C11DB7, with no final inversion. The address bytes enter from req_mac_i[47:40] down to req_mac_i[7:0], and each byte enters least significant bit first.
- R4: Index bits [7:5] choose the register and index bits [4:0] = b choose register bit 31-b. Index 0 is bit 31 of register 0 and index 255 is bit 0 of register 7.
- R5: A lookup (req_op_i=2'b00, and 2'b11 behaves the same) of a group address asserts accept_o in the done cycle exactly when the indexed table bit is 1.
- R6: When the group bit req_mac_i[40] is 0, accept_o stays 0 whatever the table holds.
- R7: A set (2'b01) writes the indexed bit to 1 and a clear (2'b10) writes it to 0, at the edge that ends the done cycle, whatever the group bit. No other table bit changes.
- R8: A request sampled with req_valid_i=1 while idle is accepted. busy_o is 1 for the 7 cycles after that edge. done_o is 1 for exactly one cycle, the 7th, which follows the edge that hashes the sixth byte.
- R9: Requests presented while busy_o is 1 are ignored. They produce no extra done pulse and no table change.
- R10: If a host write and a set/clear command update the same register at the same edge, the host value is stored. If they target different registers, both updates take effect.
- R11: accept_o is 0 outside the done cycle and during set or clear commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, taken only while idle |
| req_op_i | input | 2 | 00 lookup, 01 set, 10 clear, 11 lookup |
| req_mac_i | input | 48 | Address; [47:40] is the first byte on the wire |
| busy_o | output | 1 | Request in progress, including done cycle |
| done_o | output | 1 | One-cycle completion strobe |
| accept_o | output | 1 | Lookup result, valid with done_o |
| host_addr_i | input | 3 | Table register select |
| host_wdata_i | input | 32 | Host write data |
| host_we_i | input | 1 | Host write enable |
| host_rdata_o | output | 32 | Selected register contents |

## Verification
The bench builds the block with its defaults: six address bytes and eight registers of 32 bits. This gives the bench the real 8-bit index split into 3 select and 5 position bits. The bench searches for addresses whose indices are 0 and 255 and so reaches both ends of the table, the MSB of the first register and the LSB of the last. It also finds a non-group address that hashes onto a set entry, so the group-bit gate is checked against a table hit and not just an empty table.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'b00,
    OP_SET    = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_RSVD   = 2'b11
  } mhf_op_e;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  // one byte, LSB first, MSB-first shift register
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
    return r;
  endfunction

endpackage

// File: rtl/mhf_crc.sv
module mhf_crc #(
  parameter int OUT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             en_i,
  input  logic [7:0]       byte_i,
  output logic [OUT_W-1:0] idx_o
);
  import mhf_pkg::*;

  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (init_i) crc_q <= '1;
    else if (en_i)   crc_q <= crc_step_byte(crc_q, byte_i);
  end

  assign idx_o = crc_q[31 -: OUT_W];

endmodule

// File: rtl/mhf_ctrl.sv
module mhf_ctrl #(
  parameter int ADDR_BYTES = 6,
  localparam int MAC_W     = 8 * ADDR_BYTES,
  localparam int CNT_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  mhf_pkg::mhf_op_e req_op_i,
  input  logic [MAC_W-1:0] req_mac_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             crc_init_o,
  output logic             crc_en_o,
  output logic [7:0]       byte_o,
  output mhf_pkg::mhf_op_e op_o,
  output logic             group_o
);
  import mhf_pkg::*;

  typedef enum logic [1:0] {ST_IDLE, ST_HASH, ST_DONE} state_e;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

  state_e           state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [MAC_W-1:0] mac_q;
  mhf_op_e          op_q;
  logic             group_q;

  assign crc_init_o = (state_q == ST_IDLE) && req_valid_i;
  assign crc_en_o   = (state_q == ST_HASH);
  assign byte_o     = mac_q[MAC_W-1 -: 8];
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign op_o       = op_q;
  assign group_o    = group_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mac_q   <= '0;
      op_q    <= OP_LOOKUP;
      group_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          state_q <= ST_HASH;
          cnt_q   <= '0;
          mac_q   <= req_mac_i;
          op_q    <= req_op_i;
          group_q <= req_mac_i[MAC_W-8];
        end
        ST_HASH: begin
          mac_q <= mac_q << 8;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(crc_en_o && cnt_q == LAST));
  assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i));
  assert_hold_when_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_en_o |=> $stable(op_q) && $stable(group_q));

endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 32,
  localparam int SEL_W   = $clog2(NUM_REGS),
  localparam int BIT_W   = $clog2(REG_W),
  localparam int IDX_W   = SEL_W + BIT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] host_addr_i,
  input  logic [REG_W-1:0] host_wdata_i,
  input  logic             host_we_i,
  output logic [REG_W-1:0] host_rdata_o,
  input  logic             upd_en_i,
  input  logic             upd_set_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             hit_o
);

  logic [REG_W-1:0]          regs_q [NUM_REGS];
  logic [NUM_REGS*REG_W-1:0] flat;
  logic [SEL_W-1:0]          sel;
  logic [BIT_W-1:0]          pos;
  logic [REG_W-1:0]          mask;

  assign sel  = idx_i[IDX_W-1 -: SEL_W];
  // MSB-first numbering within a register
  assign pos  = BIT_W'(REG_W - 1) - idx_i[BIT_W-1:0];
  assign mask = REG_W'(1) << pos;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[g] <= '0;
      else if (host_we_i && host_addr_i == SEL_W'(g))
        regs_q[g] <= host_wdata_i;
      else if (upd_en_i && sel == SEL_W'(g))
        regs_q[g] <= upd_set_i ? (regs_q[g] | mask) : (regs_q[g] & ~mask);
    end
    assign flat[g*REG_W +: REG_W] = regs_q[g];

    assert_host_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      host_we_i && host_addr_i == SEL_W'(g) |=> regs_q[g] == $past(host_wdata_i));
  end

  assign host_rdata_o = regs_q[host_addr_i];
  assign hit_o        = regs_q[sel][pos];

  assert_one_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && !host_we_i |=> $countones(flat ^ $past(flat)) <= 1);
  assert_table_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i && !host_we_i |=> $stable(flat));

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int NUM_REGS   = 8,
  parameter int REG_W      = 32,
  localparam int MAC_W     = 8 * ADDR_BYTES,
  localparam int SEL_W     = $clog2(NUM_REGS),
  localparam int IDX_W     = SEL_W + $clog2(REG_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_op_i,
  input  logic [MAC_W-1:0] req_mac_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             accept_o,
  input  logic [SEL_W-1:0] host_addr_i,
  input  logic [REG_W-1:0] host_wdata_i,
  input  logic             host_we_i,
  output logic [REG_W-1:0] host_rdata_o
);
  import mhf_pkg::*;

  logic             crc_init, crc_en, group, hit, is_upd;
  logic [7:0]       byte_cur;
  logic [IDX_W-1:0] idx;
  mhf_op_e          op;

  mhf_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i,
    .req_op_i   (mhf_op_e'(req_op_i)),
    .req_mac_i,
    .busy_o, .done_o,
    .crc_init_o (crc_init),
    .crc_en_o   (crc_en),
    .byte_o     (byte_cur),
    .op_o       (op),
    .group_o    (group)
  );

  mhf_crc #(.OUT_W(IDX_W)) u_crc (
    .clk_i, .rst_ni,
    .init_i (crc_init),
    .en_i   (crc_en),
    .byte_i (byte_cur),
    .idx_o  (idx)
  );

  assign is_upd = (op == OP_SET) || (op == OP_CLEAR);

  mhf_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_table (
    .clk_i, .rst_ni,
    .host_addr_i, .host_wdata_i, .host_we_i, .host_rdata_o,
    .upd_en_i  (done_o && is_upd),
    .upd_set_i (op == OP_SET),
    .idx_i     (idx),
    .hit_o     (hit)
  );

  assign accept_o = done_o && !is_upd && group && hit;

  assert_accept_in_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> done_o && !is_upd);
  assert_accept_group_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> group);
  assert_done_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

endmodule

// File: tb/mcast_hash_filter_tb_top.sv
module mcast_hash_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [47:0] req_mac = '0;
  logic        busy, done, accept;
  logic [2:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_we = 1'b0;
  logic [31:0] host_rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mcast_hash_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_mac_i(req_mac),
    .busy_o(busy), .done_o(done), .accept_o(accept),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata), .host_we_i(host_we),
    .host_rdata_o(host_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bit-serial model of the hash
  function automatic logic [7:0] ref_idx(input logic [47:0] mac);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      logic d  = mac[47 - 8*(k/8) - 7 + (k%8)];
      logic fb = c[31] ^ d;
      c = (c << 1) ^ (fb ? 32'h04C1_1DB7 : 32'h0);
    end
    return c[31:24];
  endfunction

  function automatic logic [47:0] find_mac(input logic [7:0] target, input logic [47:0] base);
    for (int i = 0; i < 65536; i++) begin
      logic [47:0] m = base | 48'(i);
      if (ref_idx(m) == target) return m;
    end
    return base;
  endfunction

  function automatic logic [31:0] bit_mask(input logic [7:0] idx);
    return 32'h1 << (31 - idx[4:0]);
  endfunction

  task automatic host_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  // issues one command; optional stray request mid-run and host write in done cycle
  task automatic run_cmd(input logic [1:0] op, input logic [47:0] mac,
                         input bit stray, input bit hwe, input logic [2:0] ha,
                         input logic [31:0] hd, output logic acc);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_mac = mac;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      req_valid = (stray && n == 2);
      if (stray && n == 2) begin req_op = 2'b01; req_mac = ~mac; end
      check("R8 busy", 32'(busy), 32'h1);
      check("R8 done", 32'(done), 32'h0);
      check("R11 accept outside done", 32'(accept), 32'h0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 done pulse", 32'(done), 32'h1);
    check("R8 busy in done", 32'(busy), 32'h1);
    acc = accept;
    if (hwe) begin host_addr = ha; host_wdata = hd; host_we = 1'b1; end
    @(negedge clk);
    host_we = 1'b0;
    check("R8 idle after done", 32'(busy), 32'h0);
    check("R9 no extra done", 32'(done), 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 busy", 32'(busy), 32'h0);
    check("R1 done", 32'(done), 32'h0);
    check("R1 accept", 32'(accept), 32'h0);
    for (int r = 0; r < 8; r++) begin
      host_read(3'(r), d);
      check("R1 reg zero", d, 32'h0);
    end
  endtask

  task automatic t_host;
    logic [31:0] d;
    for (int r = 0; r < 8; r++) host_write(3'(r), 32'hC0DE_0000 | 32'(r));
    for (int r = 0; r < 8; r++) begin
      host_read(3'(r), d);
      check("R2 readback", d, 32'hC0DE_0000 | 32'(r));
    end
    for (int r = 0; r < 8; r++) host_write(3'(r), 32'h0);
  endtask

  task automatic t_set_lookup_clear(input logic [47:0] a, input logic [47:0] b);
    logic acc;
    logic [31:0] d;
    logic [7:0] ia = ref_idx(a);
    run_cmd(2'b01, a, 0, 0, 0, 0, acc);
    check("R11 accept on set", 32'(acc), 32'h0);
    for (int r = 0; r < 8; r++) begin
      host_read(3'(r), d);
      check("R3 R4 R7 set bit", d, (3'(r) == ia[7:5]) ? bit_mask(ia) : 32'h0);
    end
    run_cmd(2'b00, a, 0, 0, 0, 0, acc);
    check("R5 lookup hit", 32'(acc), 32'h1);
    run_cmd(2'b11, a, 0, 0, 0, 0, acc);
    check("R5 op 11 as lookup", 32'(acc), 32'h1);
    run_cmd(2'b00, b, 0, 0, 0, 0, acc);
    check("R5 lookup miss", 32'(acc), 32'h0);
    run_cmd(2'b10, a, 0, 0, 0, 0, acc);
    host_read(ia[7:5], d);
    check("R7 clear bit", d, 32'h0);
    run_cmd(2'b00, a, 0, 0, 0, 0, acc);
    check("R5 lookup after clear", 32'(acc), 32'h0);
  endtask

  task automatic t_non_group(input logic [47:0] c);
    logic acc;
    logic [31:0] d;
    logic [7:0] ic = ref_idx(c);
    run_cmd(2'b01, c, 0, 0, 0, 0, acc);
    host_read(ic[7:5], d);
    check("R7 set ignores group bit", d, bit_mask(ic));
    run_cmd(2'b00, c, 0, 0, 0, 0, acc);
    check("R6 non-group rejected", 32'(acc), 32'h0);
    host_write(ic[7:5], 32'h0);
  endtask

  task automatic t_busy_ignore(input logic [47:0] a);
    logic acc;
    logic [31:0] d;
    run_cmd(2'b00, a, 1, 0, 0, 0, acc);
    repeat (8) @(negedge clk);
    check("R9 stray idle", 32'(busy), 32'h0);
    for (int r = 0; r < 8; r++) begin
      host_read(3'(r), d);
      check("R9 table untouched", d, 32'h0);
    end
  endtask

  task automatic t_collide(input logic [47:0] a);
    logic acc;
    logic [31:0] d;
    logic [7:0] ia = ref_idx(a);
    logic [2:0] other = ia[7:5] + 3'd1;
    run_cmd(2'b01, a, 0, 1, ia[7:5], 32'hA5A5_0000 & ~bit_mask(ia), acc);
    host_read(ia[7:5], d);
    check("R10 host wins same reg", d, 32'hA5A5_0000 & ~bit_mask(ia));
    host_write(ia[7:5], 32'h0);
    run_cmd(2'b01, a, 0, 1, other, 32'h0000_1234, acc);
    host_read(ia[7:5], d);
    check("R10 command applied", d, bit_mask(ia));
    host_read(other, d);
    check("R10 host applied", d, 32'h0000_1234);
    host_write(ia[7:5], 32'h0);
    host_write(other, 32'h0);
  endtask

  task automatic t_edges;
    logic acc;
    logic [31:0] d;
    logic [47:0] m0 = find_mac(8'h00, 48'h0100_5E00_0000);
    logic [47:0] m1 = find_mac(8'hFF, 48'h0100_5E00_0000);
    check("R3 index 0 found", 32'(ref_idx(m0)), 32'h00);
    check("R3 index 255 found", 32'(ref_idx(m1)), 32'hFF);
    run_cmd(2'b01, m0, 0, 0, 0, 0, acc);
    run_cmd(2'b01, m1, 0, 0, 0, 0, acc);
    host_read(3'd0, d);
    check("R4 index 0 -> reg0 bit31", d, 32'h8000_0000);
    host_read(3'd7, d);
    check("R4 index 255 -> reg7 bit0", d, 32'h0000_0001);
    run_cmd(2'b00, m1, 0, 0, 0, 0, acc);
    check("R5 lookup at index 255", 32'(acc), 32'h1);
    host_write(3'd0, 32'h0);
    host_write(3'd7, 32'h0);
  endtask

  initial begin
    logic [47:0] a, b, c;
    a = find_mac(8'h5C, 48'h0100_5E00_0000);
    b = find_mac(8'h13, 48'h0100_5E00_0000);
    c = find_mac(8'hA7, 48'h0200_5E00_0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_host();
    t_set_lookup_clear(a, b);
    t_non_group(c);
    t_busy_ignore(a);
    t_collide(a);
    t_edges();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule